// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This engine moves one device sector between a byte-stream device and byte-addressed physical memory. The sector may be split over several separate buffers. Software places a list of descriptors in memory and starts the engine with the list's physical address and a direction flag. Each descriptor names a buffer and its length. The engine reads the descriptors in turn. In scatter mode it writes incoming device bytes into the buffers. In gather mode it reads the buffers out to the device. A descriptor whose length is zero ends the list.

All addresses are used exactly as given. No translation is applied. The memory side is a byte-wide port that always accepts a request. Read data appears one cycle after the request. When the list ends, the engine reports whether the lengths it was given add up to one sector.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset `busy`, `done`, `len_err`, `mem_req`, `dev_in_ready` and `dev_out_valid` are all low, and no memory request is made while the engine is idle.
- R2: A descriptor is 8 bytes at `list_base + 8*i`, fetched in list order. Bytes 0..3 hold the buffer address and bytes 4..7 hold the byte count, each least significant byte first.
- R3: In scatter mode the k-th device byte of a buffer is written to buffer address + k, and no byte outside the buffer is written. A memory write happens only in a cycle where `dev_in_valid` and `dev_in_ready` are both high.
- R4: In gather mode the buffer bytes are sent on `dev_out_data` in address order, buffer after buffer. While `dev_out_ready` is low, `dev_out_valid` and the data are held.
- R5: A zero-count descriptor ends the transfer. After it, no further memory write or device byte occurs. `done` pulses for one cycle, and in that same cycle `busy` falls.
- R6: At completion `len_err` is 1 exactly when the nonzero counts sum to something other than SECTOR (512 by default). This includes an empty list. The value holds until the next accepted start, which clears it.
- R7: A start request while `busy` is high is ignored. A start in the cycle `done` is high is accepted, and `busy` is high in the following cycle.
- R8: `dev_in_ready` is high only during a scatter transfer and `dev_out_valid` only during a gather transfer. The two are never high together.
- R9: The list base and direction are captured when a start is accepted (`start_gather` = 1 selects gather). `busy` is high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, taken only when idle |
| start_gather | input | 1 | Direction for the start: 1 gather, 0 scatter |
| list_base | input | AW | Physical address of the descriptor list |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| len_err | output | 1 | Counts did not total one sector |
| mem_req | output | 1 | Memory byte access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| dev_in_valid | input | 1 | Device byte offered (scatter) |
| dev_in_ready | output | 1 | Engine takes a device byte |
| dev_in_data | input | 8 | Device byte |
| dev_out_valid | output | 1 | Byte offered to device (gather) |
| dev_out_ready | input | 1 | Device accepts the byte |
| dev_out_data | output | 8 | Byte to device |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. The bench holds `start` high, with a second list base and the opposite direction, for the whole of a scatter transfer. It judges three things: the first transfer's buffers must hold exactly the device bytes, so the held start was ignored while busy; `busy` must be high one cycle after `done`; and the second transfer's gather stream must match the second list's buffers.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_SCAT,
        ST_GRD,
        ST_GCAP,
        ST_GSEND
    } eng_state_e;

    localparam int WORD_W     = 32;
    localparam int DESC_BYTES = 2 * WORD_W / 8;
endpackage

// File: rtl/sg_desc_loader.sv
module sg_desc_loader #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [7:0]        cap_byte,
    output logic [WORD_W-1:0] addr_word,
    output logic [WORD_W-1:0] cnt_word
);
    localparam int DW = 2 * WORD_W;

    logic [DW-1:0] sh_d, sh_q;

    // bytes arrive lowest first; shifting in from the top leaves byte 0 at the bottom
    always_comb begin
        sh_d = sh_q;
        if (cap) begin
            sh_d = {cap_byte, sh_q[DW-1:8]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign addr_word = sh_q[WORD_W-1:0];
    assign cnt_word  = sh_q[DW-1:WORD_W];
endmodule

// File: rtl/sg_len_tally.sv
module sg_len_tally #(
    parameter int CW     = 32,
    parameter int SECTOR = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [CW-1:0] amount,
    output logic          mismatch
);
    typedef struct packed {
        logic [CW-1:0] total;
        logic          ovf;
    } tally_t;

    tally_t d, q;

    always_comb begin
        logic [CW:0] sum;
        d   = q;
        sum = {1'b0, q.total} + {1'b0, amount};
        if (clr) begin
            d.total = '0;
            d.ovf   = 1'b0;
        end else if (add_en) begin
            d.total = sum[CW-1:0];
            d.ovf   = q.ovf | sum[CW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mismatch = q.ovf || (q.total != CW'(SECTOR));
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sg_dma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int CW     = 32,
    parameter int SECTOR = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_gather,
    input  logic [AW-1:0] list_base,
    output logic          busy,
    output logic          done,
    output logic          len_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [7:0]    dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [7:0]    dev_out_data
);
    localparam int FIW = $clog2(DESC_BYTES) + 1;

    typedef struct packed {
        eng_state_e     st;
        logic           gather;
        logic [AW-1:0]  ptr;
        logic [AW-1:0]  cur;
        logic [CW-1:0]  remain;
        logic [FIW-1:0] fidx;
        logic [FIW-1:0] cidx;
        logic           rd_pend;
        logic [7:0]     obuf;
        logic           done;
        logic           len_err;
    } eng_t;

    eng_t d, q;

    logic              ld_cap;
    logic              tally_clr;
    logic              tally_add;
    logic              len_mismatch;
    logic [WORD_W-1:0] addr_word;
    logic [WORD_W-1:0] cnt_word;

    sg_desc_loader #(.WORD_W(WORD_W)) loader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (ld_cap),
        .cap_byte  (mem_rdata),
        .addr_word (addr_word),
        .cnt_word  (cnt_word)
    );

    sg_len_tally #(.CW(CW), .SECTOR(SECTOR)) tally_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tally_clr),
        .add_en   (tally_add),
        .amount   (CW'(cnt_word)),
        .mismatch (len_mismatch)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.rd_pend = 1'b0;
        ld_cap    = 1'b0;
        tally_clr = 1'b0;
        tally_add = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.cur;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_FETCH;
                    d.gather  = start_gather;
                    d.ptr     = list_base;
                    d.fidx    = '0;
                    d.cidx    = '0;
                    d.len_err = 1'b0;
                    tally_clr = 1'b1;
                end
            end
            ST_FETCH: begin
                // one read issued per cycle; each byte captured the cycle after
                if (q.fidx < FIW'(DESC_BYTES)) begin
                    mem_req   = 1'b1;
                    mem_addr  = q.ptr + AW'(q.fidx);
                    d.fidx    = q.fidx + 1'b1;
                    d.rd_pend = 1'b1;
                end
                if (q.rd_pend) begin
                    ld_cap = 1'b1;
                    d.cidx = q.cidx + 1'b1;
                    if (q.cidx == FIW'(DESC_BYTES - 1)) begin
                        d.st = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                if (cnt_word == '0) begin
                    d.st      = ST_IDLE;
                    d.done    = 1'b1;
                    d.len_err = len_mismatch;
                end else begin
                    tally_add = 1'b1;
                    d.cur     = AW'(addr_word);
                    d.remain  = CW'(cnt_word);
                    d.ptr     = q.ptr + AW'(DESC_BYTES);
                    d.fidx    = '0;
                    d.cidx    = '0;
                    d.st      = q.gather ? ST_GRD : ST_SCAT;
                end
            end
            ST_SCAT: begin
                if (dev_in_valid) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    d.cur    = q.cur + 1'b1;
                    d.remain = q.remain - 1'b1;
                    if (q.remain == CW'(1)) begin
                        d.st = ST_FETCH;
                    end
                end
            end
            ST_GRD: begin
                mem_req = 1'b1;
                d.st    = ST_GCAP;
            end
            ST_GCAP: begin
                d.obuf = mem_rdata;
                d.st   = ST_GSEND;
            end
            ST_GSEND: begin
                if (dev_out_ready) begin
                    d.cur    = q.cur + 1'b1;
                    d.remain = q.remain - 1'b1;
                    d.st     = (q.remain == CW'(1)) ? ST_FETCH : ST_GRD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.st != ST_IDLE);
    assign done          = q.done;
    assign len_err       = q.len_err;
    assign mem_wdata     = dev_in_data;
    assign dev_in_ready  = (q.st == ST_SCAT);
    assign dev_out_valid = (q.st == ST_GSEND);
    assign dev_out_data  = q.obuf;
endmodule

// File: rtl/sg_dma_engine_chk.sv
module sg_dma_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       len_err,
    input logic       mem_req,
    input logic       mem_we,
    input logic       dev_in_valid,
    input logic       dev_in_ready,
    input logic       dev_out_valid,
    input logic       dev_out_ready,
    input logic [7:0] dev_out_data
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_write_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (dev_in_valid && dev_in_ready));

    p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_err_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err != $past(len_err)) |-> (done || $past(start && !busy)));

    p_dir_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_in_ready && dev_out_valid));
endmodule

bind sg_dma_engine sg_dma_engine_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .len_err       (len_err),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .dev_in_valid  (dev_in_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data)
);

// File: tb/sg_dma_engine_tb_top.sv
module sg_dma_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEMSZ      = 4096;
    localparam int AW         = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          start_gather;
    logic [AW-1:0] list_base;
    logic          busy, done, len_err;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          dev_in_valid;
    logic          dev_in_ready;
    logic [7:0]    dev_in_data;
    logic          dev_out_valid;
    logic          dev_out_ready;
    logic [7:0]    dev_out_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sg_dma_engine dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .start_gather (start_gather),
        .list_base (list_base), .busy (busy), .done (done), .len_err (len_err),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .dev_in_valid (dev_in_valid), .dev_in_ready (dev_in_ready),
        .dev_in_data (dev_in_data), .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready), .dev_out_data (dev_out_data)
    );

    logic [7:0] mem [0:MEMSZ-1];
    int wr_count  = 0;
    int outv_cnt  = 0;
    int inr_cnt   = 0;
    int total     = 0;
    int bad       = 0;

    int         n_ch;
    int         ch_cnt [4];
    int         ch_adr [4];
    logic [7:0] got [0:1023];
    int         got_n;

    // memory model: always accepts, read data one cycle later
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                wr_count <= wr_count + 1;
            end else begin
                mem_rdata <= mem[mem_addr[11:0]];
            end
        end
    end

    always @(negedge clk) begin
        if (dev_out_valid) outv_cnt <= outv_cnt + 1;
        if (dev_in_ready)  inr_cnt  <= inr_cnt + 1;
    end

    function automatic logic [7:0] src_byte(int r, int k);
        return 8'(k * 7 + r * 13 + 5);
    endfunction

    function automatic logic [7:0] mem_pat(int r, int a);
        return 8'(a * 5 + r * 11 + 3);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put_word(int a, logic [31:0] w);
        for (int b = 0; b < 4; b++) mem[a + b] = w[8*b +: 8];
    endtask

    task automatic build_list(int base);
        for (int i = 0; i < n_ch; i++) begin
            put_word(base + 8 * i, 32'(ch_adr[i]));
            put_word(base + 8 * i + 4, 32'(ch_cnt[i]));
        end
        put_word(base + 8 * n_ch, 32'h0000_0FF0);
        put_word(base + 8 * n_ch + 4, 32'h0);
    endtask

    function automatic int list_sum();
        int s = 0;
        for (int i = 0; i < n_ch; i++) s += ch_cnt[i];
        return s;
    endfunction

    task automatic start_xfer(int base, bit gath);
        @(negedge clk);
        start        = 1'b1;
        list_base    = AW'(base);
        start_gather = gath;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        check(len_err == 1'b0, "R6", "len_err cleared by start", int'(len_err), 0);
    endtask

    task automatic feed(int r, int n, int mode);
        int k = 0;
        int cyc = 0;
        while (k < n) begin
            @(negedge clk);
            if ((mode == 1 && cyc % 3 == 0) || (mode == 2 && cyc % 2 == 1)) begin
                dev_in_valid = 1'b0;
            end else begin
                dev_in_valid = 1'b1;
                dev_in_data  = src_byte(r, k);
                if (dev_in_ready) k++;
            end
            cyc++;
        end
        @(negedge clk);
        dev_in_valid = 1'b0;
    endtask

    task automatic drain(int n, int mode);
        int cyc = 0;
        got_n = 0;
        while (got_n < n) begin
            @(negedge clk);
            dev_out_ready = !((mode == 1 && cyc % 2 == 0) || (mode == 2 && cyc % 3 == 1));
            if (dev_out_valid && dev_out_ready) begin
                got[got_n] = dev_out_data;
                got_n++;
            end
            cyc++;
        end
        @(negedge clk);
        dev_out_ready = 1'b0;
    endtask

    task automatic wait_done(bit exp_err);
        bit seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        check(seen, "R5", "done pulse seen", int'(seen), 1);
        check(busy == 1'b0, "R5", "busy low with done", int'(busy), 0);
        check(len_err == exp_err, "R6", "len_err at completion", int'(len_err), int'(exp_err));
        @(negedge clk);
        check(done == 1'b0, "R5", "done lasts one cycle", int'(done), 0);
        check(len_err == exp_err, "R6", "len_err held", int'(len_err), int'(exp_err));
    endtask

    task automatic check_scatter(int r, int wb, int ob);
        int errs = 0;
        int k = 0;
        int s = list_sum();
        for (int i = 0; i < n_ch; i++) begin
            if (mem[ch_adr[i] - 1] != 8'hEE) errs++;
            if (mem[ch_adr[i] + ch_cnt[i]] != 8'hEE) errs++;
            for (int j = 0; j < ch_cnt[i]; j++) begin
                if (mem[ch_adr[i] + j] != src_byte(r, k)) errs++;
                k++;
            end
        end
        check(errs == 0, "R3", "scatter buffer contents (R2 order)", errs, 0);
        check(wr_count - wb == s, "R5", "write count", wr_count - wb, s);
        check(outv_cnt == ob, "R8", "no device output in scatter", outv_cnt - ob, 0);
    endtask

    task automatic check_gather(int r, int wb, int ib);
        int errs = 0;
        int k = 0;
        for (int i = 0; i < n_ch; i++) begin
            for (int j = 0; j < ch_cnt[i]; j++) begin
                if (k >= got_n || got[k] != mem_pat(r, ch_adr[i] + j)) errs++;
                k++;
            end
        end
        check(errs == 0, "R4", "gather stream order (R2 order)", errs, 0);
        check(wr_count == wb, "R4", "no memory writes in gather", wr_count - wb, 0);
        check(inr_cnt == ib, "R8", "no device input ready in gather", inr_cnt - ib, 0);
    endtask

    task automatic run_scatter(int r, int mode);
        int wb, ob, s;
        s = list_sum();
        for (int a = 0; a < MEMSZ; a++) mem[a] = 8'hEE;
        build_list(32'h100);
        @(negedge clk);
        wb = wr_count;
        ob = outv_cnt;
        start_xfer(32'h100, 1'b0);
        fork
            feed(r, s, mode);
            wait_done(s != 512);
        join
        check_scatter(r, wb, ob);
    endtask

    task automatic run_gather(int r, int mode);
        int wb, ib, s;
        s = list_sum();
        for (int a = 0; a < MEMSZ; a++) mem[a] = mem_pat(r, a);
        build_list(32'h100);
        @(negedge clk);
        wb = wr_count;
        ib = inr_cnt;
        start_xfer(32'h100, 1'b1);
        fork
            drain(s, mode);
            wait_done(s != 512);
        join
        check_gather(r, wb, ib);
    endtask

    task automatic set_two(int first, int second);
        n_ch = 2;
        ch_adr[0] = 32'h400; ch_cnt[0] = first;
        ch_adr[1] = 32'h800; ch_cnt[1] = second;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int splits [5];
        int wb, ob, r;
        splits = '{1, 100, 256, 411, 511};
        rst_n = 1'b0; start = 1'b0; start_gather = 1'b0; list_base = '0;
        dev_in_valid = 1'b0; dev_in_data = '0; dev_out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && len_err == 0, "R1", "status after reset",
              int'({busy, done, len_err}), 0);
        check(mem_req == 1'b0, "R1", "no memory request idle", int'(mem_req), 0);
        check(dev_in_ready == 0 && dev_out_valid == 0, "R1", "device side idle",
              int'({dev_in_ready, dev_out_valid}), 0);

        // two-chunk split sweep, both directions, various stall patterns
        for (int i = 0; i < 5; i++) begin
            set_two(splits[i], 512 - splits[i]);
            run_scatter(i, i % 3);
            run_gather(i, i % 3);
        end

        // single chunk and three chunks
        n_ch = 1; ch_adr[0] = 32'h400; ch_cnt[0] = 512;
        run_scatter(7, 1);
        run_gather(7, 2);
        n_ch = 3;
        ch_adr[0] = 32'h400; ch_cnt[0] = 100;
        ch_adr[1] = 32'h800; ch_cnt[1] = 312;
        ch_adr[2] = 32'hC00; ch_cnt[2] = 100;
        run_scatter(8, 2);
        run_gather(8, 1);

        // R6: short and long totals, then empty list
        n_ch = 1; ch_adr[0] = 32'h400; ch_cnt[0] = 300;
        run_scatter(9, 0);
        set_two(400, 200);
        run_gather(10, 0);
        n_ch = 0;
        run_scatter(11, 0);
        // R6: correct run after an error clears the flag
        set_two(100, 412);
        run_scatter(12, 0);

        // R7: start held through a scatter run with a second list; accepted at done
        r = 13;
        for (int a = 0; a < MEMSZ; a++) mem[a] = mem_pat(r, a);
        n_ch = 1; ch_adr[0] = 32'hC00; ch_cnt[0] = 512;
        build_list(32'h180);
        set_two(200, 312);
        build_list(32'h100);
        for (int a = 0; a < 512; a++) begin
            if (a < 200) mem[32'h400 + a] = 8'hEE;
        end
        mem[32'h3FF] = 8'hEE; mem[32'h4C8] = 8'hEE;
        mem[32'h7FF] = 8'hEE; mem[32'h938] = 8'hEE;
        @(negedge clk);
        wb = wr_count;
        ob = outv_cnt;
        start_xfer(32'h100, 1'b0);
        start        = 1'b1;
        list_base    = AW'(32'h180);
        start_gather = 1'b1;
        fork
            feed(r, 512, 1);
            begin
                wait_done(1'b0);
                check(busy == 1'b1, "R7", "start in done cycle accepted", int'(busy), 1);
                start = 1'b0;
                wait_done(1'b0);
            end
            drain(512, 0);
        join
        begin
            int errs = 0;
            for (int j = 0; j < 200; j++) if (mem[32'h400 + j] != src_byte(r, j)) errs++;
            for (int j = 0; j < 312; j++) if (mem[32'h800 + j] != src_byte(r, 200 + j)) errs++;
            check(errs == 0, "R7", "held start ignored while busy", errs, 0);
            check(wr_count - wb == 512, "R7", "first run write count", wr_count - wb, 512);
            errs = 0;
            for (int j = 0; j < 512; j++) if (got[j] != mem_pat(r, 32'hC00 + j)) errs++;
            check(errs == 0, "R9", "second run used latched base and direction", errs, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule